// File: doc/BRIEF.md
# Scan-chain debug bridge

This block sits between a serial test-access shift port and the debug port of a CPU core. A TAP controller outside the block supplies a 2-bit instruction and three strobes: capture, shift and update. The block picks one of four data registers of different lengths from the instruction. It loads that register on capture, moves it one bit per shift, least significant bit first, between `tdi` and `tdo`, and acts on its contents at update.

Update commands run in the scan clock domain. Each one that is committed is held in a register and announced to the core clock domain by flipping a toggle bit. A three-flop detector turns each toggle into exactly one core-cycle pulse on `dbg_run` or `dbg_wen`. The halt request and the reset request are levels, and each passes through two flops. In the other direction, the stopped flag from the core and a value-valid flag cross back through two flops each. The value-valid flag clears when a procedure is launched. It sets, and latches the core's result, when the core enters the stopped state again.

Top module: `dbg_scan_bridge`

## Requirements
- R1: The instruction code selects the data register: 0 is the identity register (32 bits), 1 is the control register (17 bits), 2 is the value register (17 bits) and 3 is the procedure register (8 bits). Data shifts least significant bit first, and `tdo` presents bit 0 of the selected register.
- R2: The identity register always captures the parameter `IDCODE_VAL`, and bits shifted into it change nothing.
- R3: On capture, control-register bit 0 reads 1 while the core is not stopped and 0 while it is stopped. Bit 1 reads back the reset request, and bits 16:2 read 0.
- R4: A control-register update with bit 16 set applies bit 0 and bit 1. Bit 0 = 0 raises `dbg_seize` and bit 0 = 1 drops it. Bit 1 drives `core_reset`.
- R5: A control-register or value-register update with bit 16 clear leaves `dbg_seize`, `core_reset` and the write outputs unchanged.
- R6: A value-register update with bit 16 set gives exactly one single-cycle `dbg_wen` pulse, with `dbg_wdata` equal to bits 15:0.
- R7: Each procedure-register update gives exactly one single-cycle `dbg_run` pulse, with `dbg_proc` equal to the 8 shifted bits.
- R8: Value-register bit 16 reads 0 after a procedure is launched and before the core stops again. From then on it reads 1, and bits 15:0 hold `dbg_result` as sampled when the stop was seen. After procedure 0 is run without a halt request, the core keeps running and bit 16 stays 0.
- R9: After reset, `dbg_seize`, `core_reset`, `dbg_run` and `dbg_wen` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| scan_rst_n | input | 1 | Scan-domain reset, active low |
| ir_sel | input | 2 | Current instruction from the TAP controller |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core-domain reset, active low |
| dbg_stopped | input | 1 | Core is halted and ready for debug |
| dbg_result | input | DATA_W | Value the core returns from a procedure |
| dbg_seize | output | 1 | Halt request to the core |
| dbg_run | output | 1 | Single-cycle procedure start |
| dbg_proc | output | PROC_W | Procedure number |
| dbg_wdata | output | DATA_W | Data for the core's temporary register |
| dbg_wen | output | 1 | Single-cycle write strobe |
| core_reset | output | 1 | Reset request to the core |

## Verification
The bench drives the identity register with all-ones input and then reads it again. A design that let shifted bits through would return a corrupted identity. The bench also sends control and value updates with the commit bit clear. A bridge that ignored the commit bit would drop the halt request or send a spurious write, and both show up at the ports.

Every update must give exactly one pulse. The bench counts pulses on a modelled core, so a broken toggle detector that gives none, or a level, shows up as a wrong count. The bench also runs procedure 0 with the halt released. A valid flag that did not clear on launch, or that set without a new stop, would report a stale result as fresh.

// File: rtl/dbg_scan_bridge.sv
module dbg_scan_bridge #(
  parameter logic [31:0] IDCODE_VAL = 32'h1D0C_A5E1,
  parameter int DATA_W = 16,
  parameter int PROC_W = 8
) (
  input  logic              tck,
  input  logic              scan_rst_n,
  input  logic [1:0]        ir_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_stopped,
  input  logic [DATA_W-1:0] dbg_result,
  output logic              dbg_seize,
  output logic              dbg_run,
  output logic [PROC_W-1:0] dbg_proc,
  output logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_wen,
  output logic              core_reset
);
  localparam int ID_W    = 32;
  localparam int VAL_LEN = DATA_W + 1;
  localparam int SR_W    = ID_W;
  localparam int LEN_W   = $clog2(SR_W + 1);

  logic [SR_W-1:0]   sr, cap;
  logic [LEN_W-1:0]  len;
  logic              run_bit, rst_bit, wr_tog, run_tog;
  logic [DATA_W-1:0] wdata_q, val_hold;
  logic [PROC_W-1:0] proc_q;
  logic [1:0]        stop_t, vld_t, seize_s, crst_s;
  logic [2:0]        wr_s, run_s, stop_s;
  logic              run_q, wen_q, val_ok;

  always_comb begin
    case (ir_sel)
      2'd0:    len = LEN_W'(ID_W);
      2'd3:    len = LEN_W'(PROC_W);
      default: len = LEN_W'(VAL_LEN);
    endcase
    cap = '0;
    case (ir_sel)
      2'd0: cap = IDCODE_VAL;
      2'd1: begin
        cap[0] = ~stop_t[1];
        cap[1] = rst_bit;
      end
      2'd2: begin
        cap[DATA_W-1:0] = val_hold;
        cap[DATA_W]     = vld_t[1];
      end
      default: cap = '0;
    endcase
  end

  assign tdo = sr[0];

  always_ff @(posedge tck or negedge scan_rst_n) begin
    if (!scan_rst_n) begin
      sr      <= '0;
      run_bit <= 1'b1;
      rst_bit <= 1'b0;
      wdata_q <= '0;
      proc_q  <= '0;
      wr_tog  <= 1'b0;
      run_tog <= 1'b0;
      stop_t  <= '0;
      vld_t   <= '0;
    end else begin
      stop_t <= {stop_t[0], stop_s[1]};
      vld_t  <= {vld_t[0], val_ok};
      if (capture_dr) begin
        sr <= cap;
      end else if (shift_dr) begin
        for (int i = 0; i < SR_W; i++)
          sr[i] <= (i == int'(len) - 1 || i == SR_W - 1) ? tdi : sr[(i + 1) % SR_W];
      end else if (update_dr) begin
        case (ir_sel)
          2'd1: if (sr[DATA_W]) begin
            run_bit <= sr[0];
            rst_bit <= sr[1];
          end
          2'd2: if (sr[DATA_W]) begin
            wdata_q <= sr[DATA_W-1:0];
            wr_tog  <= ~wr_tog;
          end
          2'd3: begin
            proc_q  <= sr[PROC_W-1:0];
            run_tog <= ~run_tog;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s     <= '0;
      run_s    <= '0;
      stop_s   <= '0;
      seize_s  <= '0;
      crst_s   <= '0;
      run_q    <= 1'b0;
      wen_q    <= 1'b0;
      val_ok   <= 1'b0;
      val_hold <= '0;
    end else begin
      wr_s    <= {wr_s[1:0], wr_tog};
      run_s   <= {run_s[1:0], run_tog};
      stop_s  <= {stop_s[1:0], dbg_stopped};
      seize_s <= {seize_s[0], ~run_bit};
      crst_s  <= {crst_s[0], rst_bit};
      run_q   <= run_s[1] ^ run_s[2];
      wen_q   <= wr_s[1] ^ wr_s[2];
      if (run_q) begin
        val_ok <= 1'b0;
      end else if (stop_s[1] && !stop_s[2]) begin
        val_ok   <= 1'b1;
        val_hold <= dbg_result;
      end
    end
  end

  assign dbg_seize  = seize_s[1];
  assign core_reset = crst_s[1];
  assign dbg_run    = run_q;
  assign dbg_wen    = wen_q;
  assign dbg_proc   = proc_q;
  assign dbg_wdata  = wdata_q;
endmodule

// File: rtl/dbg_scan_bridge_chk.sv
module dbg_scan_bridge_chk #(
  parameter int DATA_W = 16,
  parameter int PROC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_run,
  input logic              dbg_wen,
  input logic [PROC_W-1:0] dbg_proc,
  input logic [DATA_W-1:0] dbg_wdata,
  input logic              val_ok
);
  p_run_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_run |=> !dbg_run);
  p_wen_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wen |=> !dbg_wen);
  p_proc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_run |-> $stable(dbg_proc));
  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wen |-> $stable(dbg_wdata));
  p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_run |=> !val_ok);
endmodule

bind dbg_scan_bridge dbg_scan_bridge_chk #(.DATA_W(DATA_W), .PROC_W(PROC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_run(dbg_run), .dbg_wen(dbg_wen),
  .dbg_proc(dbg_proc), .dbg_wdata(dbg_wdata), .val_ok(val_ok)
);

// File: tb/dbg_scan_bridge_test.sv
module dbg_scan_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 34;
  localparam logic [31:0] ID = 32'h1D0C_A5E1;

  logic tck = 0, clk = 0, scan_rst_n = 0, rst_n = 0;
  logic [1:0] ir_sel = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, tdo;
  logic dbg_stopped, dbg_seize, dbg_run, dbg_wen, core_reset;
  logic [15:0] dbg_result, dbg_wdata;
  logic [7:0] dbg_proc;
  int checks = 0, errors = 0, run_cnt = 0, wen_cnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tck = ~tck;

  dbg_scan_bridge uut (
    .tck(tck), .scan_rst_n(scan_rst_n), .ir_sel(ir_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .clk(clk), .rst_n(rst_n), .dbg_stopped(dbg_stopped), .dbg_result(dbg_result),
    .dbg_seize(dbg_seize), .dbg_run(dbg_run), .dbg_proc(dbg_proc),
    .dbg_wdata(dbg_wdata), .dbg_wen(dbg_wen), .core_reset(core_reset)
  );

  logic [15:0] m_wdata, last_wdata;
  logic [7:0] m_proc, last_proc;
  int busy;
  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      dbg_stopped <= 0; dbg_result <= 0; busy <= 0; m_wdata <= 0; m_proc <= 0;
    end else begin
      if (dbg_wen) begin m_wdata <= dbg_wdata; wen_cnt <= wen_cnt + 1; last_wdata <= dbg_wdata; end
      if (dbg_run) begin
        run_cnt <= run_cnt + 1; last_proc <= dbg_proc;
        m_proc <= dbg_proc; busy <= 4; dbg_stopped <= 0;
      end else if (busy > 0) begin
        busy <= busy - 1;
        if (busy == 1 && !(m_proc == 0 && !dbg_seize)) begin
          dbg_stopped <= 1; dbg_result <= m_wdata ^ {8'h5A, m_proc};
        end
      end else if (dbg_seize && !dbg_stopped) begin
        dbg_stopped <= 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [1:0] ir, input int len, input logic [31:0] din,
                      output logic [31:0] dout);
    dout = 0;
    @(negedge tck); ir_sel = ir; capture_dr = 1;
    @(negedge tck); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < len; i++) begin
      tdi = din[i]; dout[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
    repeat (10) @(negedge tck);
  endtask

  task automatic t_reset;
    check("R9 seize", 32'(dbg_seize), 0);
    check("R9 core_reset", 32'(core_reset), 0);
    check("R9 pulses", 32'(run_cnt + wen_cnt), 0);
  endtask

  task automatic t_idcode;
    logic [31:0] d;
    scan(2'd0, 32, 32'hFFFF_FFFF, d);
    check("R1 idcode", d, ID);
    scan(2'd0, 32, 32'h0, d);
    check("R2 idcode unchanged", d, ID);
  endtask

  task automatic t_status;
    logic [31:0] d;
    scan(2'd1, 17, 32'h0, d);
    check("R3 running", d, 32'h1);
    scan(2'd1, 17, 32'h10000, d);
    check("R4 seize set", 32'(dbg_seize), 1);
    scan(2'd1, 17, 32'h00001, d);
    check("R3 stopped", d, 32'h0);
    check("R5 seize kept", 32'(dbg_seize), 1);
    scan(2'd1, 17, 32'h10002, d);
    check("R4 reset set", 32'(core_reset), 1);
    scan(2'd1, 17, 32'h10000, d);
    check("R3 reset readback", d, 32'h2);
    check("R4 reset cleared", 32'(core_reset), 0);
  endtask

  task automatic t_write;
    logic [31:0] d;
    scan(2'd2, 17, 32'h1BEEF, d);
    check("R6 one wen", 32'(wen_cnt), 1);
    check("R6 wdata", 32'(last_wdata), 32'hBEEF);
    scan(2'd2, 17, 32'h01234, d);
    check("R5 no wen", 32'(wen_cnt), 1);
  endtask

  task automatic t_run;
    logic [31:0] d;
    scan(2'd3, 8, 32'h13, d);
    check("R7 one run", 32'(run_cnt), 1);
    check("R7 proc", 32'(last_proc), 32'h13);
    d = 0;
    for (int k = 0; k < 20 && !d[16]; k++) scan(2'd2, 17, 32'h0, d);
    check("R8 result", d, {15'h0, 1'b1, 16'hBEEF ^ 16'h5A13});
  endtask

  task automatic t_resume;
    logic [31:0] d;
    scan(2'd1, 17, 32'h10001, d);
    check("R4 seize dropped", 32'(dbg_seize), 0);
    scan(2'd3, 8, 32'h00, d);
    check("R7 two runs", 32'(run_cnt), 2);
    scan(2'd2, 17, 32'h0, d);
    check("R8 valid clear on resume", 32'(d[16]), 0);
    scan(2'd1, 17, 32'h0, d);
    check("R8 core running", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    scan_rst_n = 1; rst_n = 1;
    repeat (4) @(negedge tck);
    t_reset; t_idcode; t_status; t_write; t_run; t_resume;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule